// File: doc/BRIEF.md
# Split-Plate Beam Position Calculator

This block turns one synchronized sample pair from the two plates of a beam position pickup into a calibrated position and a beam intensity. Each plate arrives as an in-phase and a quadrature word. The plates have already been phase-aligned further up the chain, so only the in-phase words carry information; the quadrature words are accepted and then discarded. Each plate is scaled by its own calibration gain. The normalized difference over sum is then formed with a multi-cycle restoring divider, and the raw ratio is passed through a cubic correction polynomial that comes from detector mapping.

Callers offer a sample with a one-cycle valid strobe while the block is idle. The block reports busy until the result strobe fires, and it ignores any offer made while busy. If the plate sum does not exceed a programmable floor, the block skips the division. In that case it keeps the previous position, raises an invalid flag and still reports the new intensity. Gains, the four polynomial coefficients and the floor are static configuration inputs.

Top module: `bpos_calc`

## Requirements
- R1: While reset is held and after it is released, busy, resValid, posInvalid, position and intensity are all zero.
- R2: Each plate's in-phase word is scaled as floor(I × gain / 16384). The gain is an unsigned 16-bit value in which 16384 means unity.
- R3: With every resValid, intensity equals the sum of the two scaled plate values as a signed 19-bit number. Intensity changes at no other time.
- R4: When the sum exceeds the floor and |diff| < 2 × sum, the raw ratio is floor(|diff| × 32768 / sum), with the sign of diff = scaledA − scaledB.
- R5: When |diff| ≥ 2 × sum, the raw ratio saturates to +65535 (diff ≥ 0) or −65535 (diff < 0).
- R6: When the sum is less than or equal to the unsigned floor sumThresh, position keeps its previous value, posInvalid is 1 and intensity is still updated. The next accepted sample whose sum is above the floor clears posInvalid.
- R7: Position is the cubic correction of the raw ratio x, evaluated as acc = c3 and then, for c2, c1 and c0 in turn, acc = sat18(floor(acc × x / 32768) + c). The result is a signed 18-bit value with 32768 meaning 1.0.
- R8: Busy rises on the cycle after an accepted inValid and is low in the cycle in which resValid is high. An inValid presented while busy is ignored and produces no result.
- R9: Every accepted sample produces exactly one resValid pulse, one cycle wide.
- R10: The quadrature inputs aQ and bQ have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample offer strobe |
| aI | input | 16 | Plate A in-phase, signed |
| aQ | input | 16 | Plate A quadrature, unused |
| bI | input | 16 | Plate B in-phase, signed |
| bQ | input | 16 | Plate B quadrature, unused |
| gainA | input | 16 | Plate A gain, unsigned, 16384 = 1.0 |
| gainB | input | 16 | Plate B gain, unsigned, 16384 = 1.0 |
| coef0 | input | 18 | Constant term, signed, 32768 = 1.0 |
| coef1 | input | 18 | Linear term, signed |
| coef2 | input | 18 | Square term, signed |
| coef3 | input | 18 | Cube term, signed |
| sumThresh | input | 18 | Unsigned floor on the plate sum |
| busy | output | 1 | Computation in progress |
| resValid | output | 1 | One-cycle result strobe |
| position | output | 18 | Corrected position, signed |
| intensity | output | 19 | Plate sum, signed |
| posInvalid | output | 1 | Last result had too small a sum |

## Verification
Two events can fall on the same clock edge. The result strobe fires on the same edge at which the block drops busy and becomes able to accept again. The bench holds inValid high with a new sample during the whole busy window, then checks that only the first sample's values appear at the pulse and that no second pulse follows. Saturation and the low-sum hold are each driven right at their boundaries: a sum equal to the floor, and a difference exactly twice the sum.

// File: rtl/bpos_pkg.sv
package bpos_pkg;

  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic       capture;
    logic       scale;
    logic       markLow;
    logic       satLoad;
    logic       divInit;
    logic       divStep;
    logic       signLoad;
    logic       hornStep;
    logic [1:0] coefSel;
    logic       publish;
  } bposCtrl_t;

  // Conditions reported back to the sequencer
  typedef struct packed {
    logic lowSum;
    logic overRange;
  } bposStat_t;

endpackage

// File: rtl/bpos_ctrl.sv
module bpos_ctrl
  import bpos_pkg::*;
#(
  parameter int QB = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  bposStat_t stat,
  output bposCtrl_t ctl,
  output logic      busy
);

  localparam int CNTW = $clog2(QB) + 1;
  localparam logic [CNTW-1:0] DIV_LAST = CNTW'(QB - 1);
  localparam logic [CNTW-1:0] HORN_LAST = CNTW'(2);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCALE, ST_CHECK, ST_DIV, ST_SIGN, ST_POLY, ST_DONE
  } bposState_t;

  bposState_t state, stateNext;
  logic [CNTW-1:0] stepCnt, stepCntNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepCntNext;
    end
  end

  always_comb begin
    stateNext   = state;
    stepCntNext = stepCnt;
    ctl         = '0;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          ctl.capture = 1'b1;
          stateNext   = ST_SCALE;
        end
      end
      ST_SCALE: begin
        ctl.scale = 1'b1;
        stateNext = ST_CHECK;
      end
      ST_CHECK: begin
        stepCntNext = '0;
        if (stat.lowSum) begin
          ctl.markLow = 1'b1;
          stateNext   = ST_DONE;
        end else if (stat.overRange) begin
          ctl.satLoad = 1'b1;
          stateNext   = ST_POLY;
        end else begin
          ctl.divInit = 1'b1;
          stateNext   = ST_DIV;
        end
      end
      ST_DIV: begin
        ctl.divStep = 1'b1;
        stepCntNext = stepCnt + 1'b1;
        if (stepCnt == DIV_LAST) begin
          stateNext = ST_SIGN;
        end
      end
      ST_SIGN: begin
        ctl.signLoad = 1'b1;
        stepCntNext  = '0;
        stateNext    = ST_POLY;
      end
      ST_POLY: begin
        ctl.hornStep = 1'b1;
        ctl.coefSel  = 2'(2 - int'(stepCnt));
        stepCntNext  = stepCnt + 1'b1;
        if (stepCnt == HORN_LAST) begin
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        ctl.publish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/bpos_datapath.sv
module bpos_datapath
  import bpos_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GW    = 16,
  parameter int GFRAC = 14,
  parameter int PF    = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bposCtrl_t                     ctl,
  output bposStat_t                     stat,
  input  logic signed [DW-1:0]          aI,
  input  logic signed [DW-1:0]          bI,
  input  logic [GW-1:0]                 gainA,
  input  logic [GW-1:0]                 gainB,
  input  logic signed [PF+2:0]          coef0,
  input  logic signed [PF+2:0]          coef1,
  input  logic signed [PF+2:0]          coef2,
  input  logic signed [PF+2:0]          coef3,
  input  logic [DW+GW-GFRAC-1:0]        sumThresh,
  output logic                          resValid,
  output logic signed [PF+2:0]          position,
  output logic signed [DW+GW-GFRAC:0]   intensity,
  output logic                          posInvalid
);

  localparam int SW = DW + GW - GFRAC;   // scaled plate width
  localparam int IW = SW + 1;            // sum / difference width
  localparam int RW = IW + 1;            // divider remainder width
  localparam int QB = PF + 1;            // quotient bits
  localparam int PW = PF + 2;            // raw ratio width
  localparam int CW = PF + 3;            // coefficient / result width
  localparam int HW = CW + 3;            // Horner pre-saturation width
  localparam logic signed [PW-1:0] QMAX = PW'((2 ** QB) - 1);
  localparam logic signed [HW-1:0] CMAX = HW'((2 ** (CW - 1)) - 1);
  localparam logic signed [HW-1:0] CMIN = -HW'(2 ** (CW - 1));

  // Captured plate samples and their gains
  logic signed [DW-1:0] plateIn   [2];
  logic [GW-1:0]        plateGain [2];
  logic signed [SW-1:0] plateCorr [2];

  assign plateGain[0] = gainA;
  assign plateGain[1] = gainB;

  for (genvar p = 0; p < 2; p++) begin : g_plate
    logic signed [DW+GW:0] prod;
    always_comb prod = plateIn[p] * $signed({1'b0, plateGain[p]});
    assign plateCorr[p] = prod[GFRAC +: SW];
  end

  logic signed [IW-1:0] sumR, diffR;
  logic [IW-1:0]        magDiff;
  logic [RW-1:0]        remR, remSh, divisor;
  logic [QB-1:0]        quot, bitSh;
  logic                 negR, invR;
  logic signed [PW-1:0] rawPos;
  logic signed [CW-1:0] acc;

  assign magDiff = diffR[IW-1] ? IW'(-diffR) : IW'(diffR);
  assign divisor = {1'b0, sumR};
  assign remSh   = {remR[RW-2:0], bitSh[QB-1]};

  assign stat.lowSum    = (sumR <= $signed({1'b0, sumThresh}));
  assign stat.overRange = ({1'b0, magDiff} >= {sumR, 1'b0});

  // Horner step
  logic signed [CW-1:0]    coefArr [4];
  logic signed [CW+PW-1:0] hornProd;
  logic signed [CW+1:0]    hornShift;
  logic signed [HW-1:0]    hornSum;
  logic signed [CW-1:0]    hornSat;

  assign coefArr[0] = coef0;
  assign coefArr[1] = coef1;
  assign coefArr[2] = coef2;
  assign coefArr[3] = coef3;

  always_comb begin
    hornProd  = acc * rawPos;
    hornShift = hornProd[PF +: CW+2];
    hornSum   = HW'(hornShift) + HW'(coefArr[ctl.coefSel]);
    if (hornSum > CMAX)      hornSat = CMAX[CW-1:0];
    else if (hornSum < CMIN) hornSat = CMIN[CW-1:0];
    else                     hornSat = hornSum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      plateIn[0] <= '0;
      plateIn[1] <= '0;
      sumR       <= '0;
      diffR      <= '0;
      remR       <= '0;
      quot       <= '0;
      bitSh      <= '0;
      negR       <= 1'b0;
      invR       <= 1'b0;
      rawPos     <= '0;
      acc        <= '0;
      resValid   <= 1'b0;
      position   <= '0;
      intensity  <= '0;
      posInvalid <= 1'b0;
    end else begin
      resValid <= 1'b0;
      if (ctl.capture) begin
        plateIn[0] <= aI;
        plateIn[1] <= bI;
      end
      if (ctl.scale) begin
        sumR  <= IW'(plateCorr[0]) + IW'(plateCorr[1]);
        diffR <= IW'(plateCorr[0]) - IW'(plateCorr[1]);
      end
      if (ctl.markLow) begin
        invR <= 1'b1;
      end
      if (ctl.satLoad) begin
        invR   <= 1'b0;
        rawPos <= diffR[IW-1] ? -QMAX : QMAX;
        acc    <= coef3;
      end
      if (ctl.divInit) begin
        invR  <= 1'b0;
        negR  <= diffR[IW-1];
        remR  <= RW'(magDiff >> 1);
        bitSh <= {magDiff[0], {PF{1'b0}}};
        quot  <= '0;
      end
      if (ctl.divStep) begin
        bitSh <= {bitSh[QB-2:0], 1'b0};
        if (remSh >= divisor) begin
          remR <= remSh - divisor;
          quot <= {quot[QB-2:0], 1'b1};
        end else begin
          remR <= remSh;
          quot <= {quot[QB-2:0], 1'b0};
        end
      end
      if (ctl.signLoad) begin
        rawPos <= negR ? -$signed({1'b0, quot}) : $signed({1'b0, quot});
        acc    <= coef3;
      end
      if (ctl.hornStep) begin
        acc <= hornSat;
      end
      if (ctl.publish) begin
        resValid   <= 1'b1;
        intensity  <= sumR;
        posInvalid <= invR;
        if (!invR) position <= acc;
      end
    end
  end

endmodule

// File: rtl/bpos_calc.sv
module bpos_calc
  import bpos_pkg::*;
#(
  parameter int DW    = 16,
  parameter int GW    = 16,
  parameter int GFRAC = 14,
  parameter int PF    = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic signed [DW-1:0]          aI,
  input  logic signed [DW-1:0]          aQ,
  input  logic signed [DW-1:0]          bI,
  input  logic signed [DW-1:0]          bQ,
  input  logic [GW-1:0]                 gainA,
  input  logic [GW-1:0]                 gainB,
  input  logic signed [PF+2:0]          coef0,
  input  logic signed [PF+2:0]          coef1,
  input  logic signed [PF+2:0]          coef2,
  input  logic signed [PF+2:0]          coef3,
  input  logic [DW+GW-GFRAC-1:0]        sumThresh,
  output logic                          busy,
  output logic                          resValid,
  output logic signed [PF+2:0]          position,
  output logic signed [DW+GW-GFRAC:0]   intensity,
  output logic                          posInvalid
);

  localparam int QB = PF + 1;
  localparam int CW = PF + 3;
  localparam int IW = DW + GW - GFRAC + 1;

  bposCtrl_t ctl;
  bposStat_t stat;

  // Quadrature words carry nothing once plates are phase-aligned
  logic quadUnused;
  assign quadUnused = ^{aQ, bQ};

  bpos_ctrl #(.QB(QB)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stat    (stat),
    .ctl     (ctl),
    .busy    (busy)
  );

  bpos_datapath #(.DW(DW), .GW(GW), .GFRAC(GFRAC), .PF(PF)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .stat       (stat),
    .aI         (aI),
    .bI         (bI),
    .gainA      (gainA),
    .gainB      (gainB),
    .coef0      (coef0),
    .coef1      (coef1),
    .coef2      (coef2),
    .coef3      (coef3),
    .sumThresh  (sumThresh),
    .resValid   (resValid),
    .position   (position),
    .intensity  (intensity),
    .posInvalid (posInvalid)
  );

endmodule

// File: rtl/bpos_calc_chk.sv
module bpos_calc_chk #(
  parameter int CW = 18,
  parameter int IW = 19
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 busy,
  input logic                 resValid,
  input logic                 posInvalid,
  input logic signed [CW-1:0] position,
  input logic signed [IW-1:0] intensity
);

  // R9: the result strobe is one cycle wide
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R8: an accepted offer makes the block busy
  a_r8_busy_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !busy) |=> busy);

  // R8: busy is already low when the result appears
  a_r8_idle_at_result: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !busy);

  // R6: a low-sum result leaves position untouched
  a_r6_hold_on_low: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && posInvalid) |-> $stable(position));

  // R3: intensity moves only with the result strobe
  a_r3_int_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(intensity));

  // R7: position moves only with the result strobe
  a_r7_pos_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(position));

  // R6: the invalid flag moves only with the result strobe
  a_r6_flag_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable(posInvalid));

endmodule

bind bpos_calc bpos_calc_chk #(.CW(CW), .IW(IW)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .busy       (busy),
  .resValid   (resValid),
  .posInvalid (posInvalid),
  .position   (position),
  .intensity  (intensity)
);

// File: tb/test_bpos_calc.sv
`timescale 1ns/1ps
module test_bpos_calc;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] aI = '0, aQ = '0, bI = '0, bQ = '0;
  logic [15:0] gainA = 16'd16384, gainB = 16'd16384;
  logic signed [17:0] coef0 = '0, coef1 = 18'sd32768, coef2 = '0, coef3 = '0;
  logic [17:0] sumThresh = 18'd100;
  logic busy, resValid, posInvalid;
  logic signed [17:0] position;
  logic signed [18:0] intensity;

  int checks = 0;
  int errors = 0;
  longint lastPos = 0;

  always #2.5 clk = ~clk;

  bpos_calc i_bpos_calc (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aI(aI), .aQ(aQ), .bI(bI), .bQ(bQ),
    .gainA(gainA), .gainB(gainB),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
    .sumThresh(sumThresh),
    .busy(busy), .resValid(resValid), .position(position),
    .intensity(intensity), .posInvalid(posInvalid)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat18(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  // Expected results straight from the requirements
  task automatic model(input longint ai, input longint bi,
                       output longint ePos, output longint eInt, output longint eInv);
    longint ca, cb, s, d, m, q, x, acc;
    longint cs [3];
    ca = (ai * longint'(gainA)) >>> 14;           // R2
    cb = (bi * longint'(gainB)) >>> 14;
    s = ca + cb;
    d = ca - cb;
    eInt = s;                                      // R3
    if (s <= longint'(sumThresh)) begin            // R6
      ePos = lastPos;
      eInv = 1;
      return;
    end
    eInv = 0;
    m = (d < 0) ? -d : d;
    if (m >= 2 * s) q = 65535;                     // R5
    else q = (m * 32768) / s;                      // R4
    x = (d < 0) ? -q : q;
    cs[0] = longint'(coef2);
    cs[1] = longint'(coef1);
    cs[2] = longint'(coef0);
    acc = longint'(coef3);                         // R7
    for (int k = 0; k < 3; k++) acc = sat18(((acc * x) >>> 15) + cs[k]);
    ePos = acc;
  endtask

  task automatic runOne(input string tag, input longint ai, input longint aq,
                        input longint bi, input longint bq);
    longint ePos, eInt, eInv;
    int n;
    model(ai, bi, ePos, eInt, eInv);
    @(negedge clk);
    aI = 16'(ai); aQ = 16'(aq); bI = 16'(bi); bQ = 16'(bq);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R8 busy after accept"}, longint'(busy), 1);
    n = 0;
    while (!resValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check({tag, " R9 result strobe seen"}, longint'(resValid), 1);
    check({tag, " R8 busy low at result"}, longint'(busy), 0);
    check({tag, " R7 position"}, longint'(position), ePos);
    check({tag, " R3 intensity"}, longint'(intensity), eInt);
    check({tag, " R6 invalid flag"}, longint'(posInvalid), eInv);
    lastPos = ePos;
    @(negedge clk);
    check({tag, " R9 strobe one cycle"}, longint'(resValid), 0);
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 busy in reset", longint'(busy), 0);
    check("R1 resValid in reset", longint'(resValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 position after reset", longint'(position), 0);
    check("R1 intensity after reset", longint'(intensity), 0);
    check("R1 invalid after reset", longint'(posInvalid), 0);
    check("R1 busy after reset", longint'(busy), 0);
    lastPos = 0;
  endtask

  task automatic t_ratio;
    runOne("R4 centred", 1000, 0, 1000, 0);
    runOne("R4 plate A high", 3000, 0, 1000, 0);
    runOne("R4 plate B high", 1000, 0, 3000, 0);
    runOne("R4 uneven", 12345, 0, 2222, 0);
    runOne("R4 plate B zero", 5000, 0, 0, 0);
  endtask

  task automatic t_gain;
    gainA = 16'd32768;
    runOne("R2 double gain A", 1000, 0, 1000, 0);
    gainA = 16'd12000; gainB = 16'd20000;
    runOne("R2 odd gains", -7, 0, 777, 0);
    gainA = 16'd16384; gainB = 16'd16384;
  endtask

  task automatic t_quad;
    longint p0;
    runOne("R10 quad zero", 3000, 0, 1000, 0);
    p0 = longint'(position);
    runOne("R10 quad large", 3000, 32000, 1000, -32000);
    check("R10 quad has no effect", longint'(position), p0);
  endtask

  task automatic t_low_sum;
    runOne("R6 small sum", 40, 0, 50, 0);
    runOne("R6 sum equals floor", 60, 0, 40, 0);
    runOne("R6 negative sum", -500, 0, -200, 0);
    runOne("R6 just above floor", 61, 0, 40, 0);
    check("R6 flag cleared", longint'(posInvalid), 0);
  endtask

  task automatic t_saturate;
    runOne("R5 positive", 5000, 0, -2000, 0);
    runOne("R5 negative", -2000, 0, 5000, 0);
    runOne("R5 diff equals twice sum", 3000, 0, -1000, 0);
    runOne("R5 diff just under twice sum", 3000, 0, -999, 0);
  endtask

  task automatic t_poly;
    coef0 = 18'sd1000; coef1 = 18'sd32768; coef2 = 18'sd16384; coef3 = -18'sd8192;
    runOne("R7 cubic positive", 3000, 0, 1000, 0);
    runOne("R7 cubic negative", 1000, 0, 4000, 0);
    coef0 = 18'sd131000; coef1 = 18'sd65536; coef2 = '0; coef3 = '0;
    runOne("R7 saturate high", 5000, 0, 1000, 0);
    coef0 = -18'sd131000;
    runOne("R7 saturate low", 1000, 0, 5000, 0);
    coef0 = '0; coef1 = 18'sd32768; coef2 = '0; coef3 = '0;
  endtask

  // inValid held with a different sample while busy
  task automatic t_busy_ignore;
    longint ePos, eInt, eInv;
    int n, pulses;
    model(3000, 1000, ePos, eInt, eInv);
    @(negedge clk);
    aI = 16'sd3000; bI = 16'sd1000; inValid = 1'b1;
    @(negedge clk);
    aI = 16'sd100; bI = 16'sd5000;
    n = 0;
    while (!resValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    inValid = 1'b0;
    check("R8 first sample result position", longint'(position), ePos);
    check("R8 first sample result intensity", longint'(intensity), eInt);
    lastPos = ePos;
    pulses = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (resValid) pulses++;
    end
    check("R8 offer during busy ignored", pulses, 0);
    check("R9 position unchanged after", longint'(position), ePos);
  endtask

  initial begin
    t_reset;
    t_ratio;
    t_gain;
    t_quad;
    t_low_sum;
    t_saturate;
    t_poly;
    t_busy_ignore;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired R9 actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule